// File: doc/BRIEF.md
# DMA Stream Termination and Item-Count Control

This block holds the control state and the remaining-item counter of one DMA stream. Either the DMA engine or the attached peripheral can decide when a transfer ends. Software writes a mode word and an item count while the stream is idle. Writing the mode word with the enable bit set starts the stream. Every completed item handshake then moves the counter down by one.

When the peripheral controls the flow, the counter starts at all-ones. Software recovers the number of items moved as all-ones minus the counter. The stream can stop in three ways:
- software clears the enable bit (an abort);
- the peripheral flags its final single or burst request;
- the counter runs out.

Illegal mode combinations are resolved in hardware at the moment the stream is enabled, and a sticky error bit records that this happened. Bus masters, the FIFO, address generation and arbitration are outside this block and are seen only as handshakes.

Top module: `dma_stream_term`

## Requirements
- R1: Enabling the stream with peripheral flow control (`cfg_pfc`=1 and `cfg_dir`[1]=0) loads `remaining` with 16'hFFFF, whatever count software wrote. The value is visible on the cycle after the enabling write.
- R2: While the stream is active, each cycle with `xfer_done` high lowers `remaining` by exactly one. In peripheral flow mode the items moved equal 16'hFFFF minus `remaining`, in every termination case.
- R3: In peripheral flow mode, a cycle with `per_req` and `per_last` both high arms the final request. After that, the stream ends once 1 more item completes (`burst_rd`=0) or 4 more items complete (`burst_rd`=1, BURST_BEATS=4). Ending sets `tc_flag` and does not pulse `flush`.
- R4: In peripheral flow mode, `remaining` reaching zero ends the stream and sets `tc_flag`, even when no final request has arrived.
- R5: With the DMA as flow controller, enabling loads `remaining` from the software count, and the stream ends with `tc_flag` when the count reaches zero. An enable with a software count of zero is refused: the stream stays inactive, `en_rd` stays 0 and `cfg_err` is set.
- R6: With the DMA as flow controller and circular mode on, reaching zero reloads the software count, sets `tc_flag` and keeps the stream active. When double-buffer mode is also on, each reload toggles `buf_sel`, which starts at 0.
- R7: Clearing the enable bit during a run ends the stream and sets `tc_flag`. A single-cycle `flush` pulse, coinciding with `active` falling, is given only when the direction is peripheral-to-memory (`cfg_dir`=2'b00).
- R8: If `xfer_busy` is high when the abort is written, the stream stays active with `en_rd`=0 until `xfer_done`. That item is counted in `remaining` before `active` falls.
- R9: In memory-to-memory direction (`cfg_dir`[1]=1), `pfc_rd` always reads 0, and circular and double-buffer are cleared at enable. With peripheral flow control, circular and double-buffer are also cleared at enable. Clearing either one sets `cfg_err`.
- R10: In direct mode (`cfg_direct`=1), a burst request type is downgraded to single at enable (`burst_rd`=0) and `cfg_err` is set.
- R11: `tc_flag` and `cfg_err` stay set until a `flag_clr` strobe. When a new setting event and the strobe fall in the same cycle, the set wins.
- R12: While the stream is active, count writes and mode-word writes with the enable bit set have no effect. In DMA flow mode, `per_req`/`per_last` have no effect.
- R13: On the cycle after any termination, both `active` and `en_rd` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Mode-word write strobe |
| cfg_en | input | 1 | Enable bit of the mode word |
| cfg_dir | input | 2 | Direction: 00 peripheral-to-memory, 01 memory-to-peripheral, 1x memory-to-memory |
| cfg_pfc | input | 1 | Peripheral is the flow controller |
| cfg_circ | input | 1 | Circular mode request |
| cfg_direct | input | 1 | Direct (FIFO bypass) mode |
| cfg_dbuf | input | 1 | Double-buffer mode request |
| cfg_burst | input | 1 | Burst request type (0 single) |
| cnt_wr | input | 1 | Item-count write strobe |
| cnt_wdata | input | 16 | Item count written by software |
| flag_clr | input | 1 | Clears tc_flag and cfg_err |
| per_req | input | 1 | Peripheral request |
| per_last | input | 1 | Qualifies per_req as the final request |
| xfer_busy | input | 1 | An item transfer is in flight |
| xfer_done | input | 1 | One item transfer completed this cycle |
| remaining | output | 16 | Live remaining-item counter |
| active | output | 1 | Stream is running or draining |
| en_rd | output | 1 | Enable bit readback |
| pfc_rd | output | 1 | Flow-controller select readback |
| circ_rd | output | 1 | Circular readback (resolved) |
| dbuf_rd | output | 1 | Double-buffer readback (resolved) |
| burst_rd | output | 1 | Request type readback (resolved) |
| buf_sel | output | 1 | Current double-buffer target |
| flush | output | 1 | One-cycle FIFO flush pulse |
| tc_flag | output | 1 | Sticky transfer-complete flag |
| cfg_err | output | 1 | Sticky configuration-error flag |

## Verification
The hardest situation to reach is the natural exhaustion of the counter under peripheral flow control. It needs 65535 completed items with no final request in between. The bench holds `xfer_done` high for that whole stretch and checks the last step before the counter expires as well as the step at which it does. Other corners are produced by directed sequences: an abort that overlaps an in-flight item, and a final burst request whose beats arrive back to back. Around these, seeded random runs vary the direction, the request type and the number of items before the final request.

// File: rtl/dma_term_pkg.sv
package dma_term_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } st_e;

    typedef struct packed {
        logic [1:0] dir;
        logic       pfc;
        logic       circ;
        logic       direct;
        logic       dbuf;
        logic       burst;
    } mode_t;

    localparam logic [1:0] DIR_P2M = 2'b00;

endpackage

// File: rtl/dma_term_resolve.sv
module dma_term_resolve
    import dma_term_pkg::*;
(
    input  mode_t raw,
    output mode_t eff,
    output logic  dropped
);
    logic m2m;

    always_comb begin
        m2m        = raw.dir[1];
        eff.dir    = raw.dir;
        eff.direct = raw.direct;
        eff.pfc    = raw.pfc & ~m2m;
        eff.circ   = raw.circ & ~eff.pfc & ~m2m;
        eff.dbuf   = raw.dbuf & ~eff.pfc & ~m2m;
        eff.burst  = raw.burst & ~raw.direct;
        dropped    = (raw.circ & ~eff.circ) | (raw.dbuf & ~eff.dbuf) |
                     (raw.burst & ~eff.burst);
    end
endmodule

// File: rtl/dma_term_count.sv
module dma_term_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_wr,
    input  logic [CNT_W-1:0] sw_data,
    input  logic             ld,
    input  logic             ld_all_ones,
    input  logic             dec,
    input  logic             wrap_en,
    output logic [CNT_W-1:0] cnt,
    output logic             sw_zero,
    output logic             hit_zero
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] sw;
    } cnt_t;

    cnt_t d, q;
    logic dec_ok;

    always_comb begin
        d      = q;
        dec_ok = dec && (q.cnt != '0);
        if (sw_wr) begin
            d.sw  = sw_data;
            d.cnt = sw_data;
        end
        if (ld) begin
            d.cnt = ld_all_ones ? '1 : q.sw;
        end else if (dec_ok) begin
            if (q.cnt == CNT_W'(1) && wrap_en)
                d.cnt = q.sw;
            else
                d.cnt = q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt      = q.cnt;
    assign sw_zero  = (q.sw == '0);
    assign hit_zero = dec_ok && (q.cnt == CNT_W'(1));
endmodule

// File: rtl/dma_term_last.sv
module dma_term_last #(
    parameter int BEATS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic arm,
    input  logic arm_burst,
    input  logic done,
    output logic armed,
    output logic fin
);
    localparam int LW = $clog2(BEATS + 1);

    typedef struct packed {
        logic          armed;
        logic [LW-1:0] left;
    } trk_t;

    trk_t d, q;

    always_comb begin
        d = q;
        if (start) begin
            d = '0;
        end else if (q.armed) begin
            if (done && q.left != '0) d.left = q.left - LW'(1);
        end else if (arm) begin
            d.armed = 1'b1;
            d.left  = arm_burst ? LW'(BEATS) : LW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign armed = q.armed;
    assign fin   = q.armed && done && (q.left == LW'(1));
endmodule

// File: rtl/dma_stream_term.sv
module dma_stream_term
    import dma_term_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int BURST_BEATS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_en,
    input  logic [1:0]       cfg_dir,
    input  logic             cfg_pfc,
    input  logic             cfg_circ,
    input  logic             cfg_direct,
    input  logic             cfg_dbuf,
    input  logic             cfg_burst,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             flag_clr,
    input  logic             per_req,
    input  logic             per_last,
    input  logic             xfer_busy,
    input  logic             xfer_done,
    output logic [CNT_W-1:0] remaining,
    output logic             active,
    output logic             en_rd,
    output logic             pfc_rd,
    output logic             circ_rd,
    output logic             dbuf_rd,
    output logic             burst_rd,
    output logic             buf_sel,
    output logic             flush,
    output logic             tc_flag,
    output logic             cfg_err
);
    typedef struct packed {
        st_e   st;
        logic  en;
        mode_t mode;
        logic  tc;
        logic  err;
        logic  flush;
        logic  buf_sel;
    } ctl_t;

    ctl_t d, q;

    mode_t raw, eff;
    logic  dropped;
    logic  ld, start, dec, wrap_en, sw_wr;
    logic  sw_zero, hit_zero;
    logic  arm, armed, fin;
    logic  natural_end, wrap, abort;
    logic  run_m2m, run_direct;

    always_comb begin
        raw = '{dir: cfg_dir, pfc: cfg_pfc, circ: cfg_circ, direct: cfg_direct,
                dbuf: cfg_dbuf, burst: cfg_burst};
    end

    dma_term_resolve u_res (
        .raw     (raw),
        .eff     (eff),
        .dropped (dropped)
    );

    assign sw_wr   = cnt_wr && (q.st == ST_IDLE);
    assign dec     = xfer_done && (q.st != ST_IDLE);
    assign wrap_en = q.mode.circ && (q.st == ST_RUN);
    assign arm     = per_req && per_last && (q.st == ST_RUN) && q.mode.pfc && !armed;

    dma_term_count #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_wr       (sw_wr),
        .sw_data     (cnt_wdata),
        .ld          (ld),
        .ld_all_ones (eff.pfc),
        .dec         (dec),
        .wrap_en     (wrap_en),
        .cnt         (remaining),
        .sw_zero     (sw_zero),
        .hit_zero    (hit_zero)
    );

    dma_term_last #(.BEATS(BURST_BEATS)) u_last (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .arm       (arm),
        .arm_burst (q.mode.burst),
        .done      (dec),
        .armed     (armed),
        .fin       (fin)
    );

    always_comb begin
        d           = q;
        d.flush     = 1'b0;
        ld          = 1'b0;
        start       = 1'b0;
        abort       = cfg_wr && !cfg_en;
        natural_end = q.mode.pfc ? (hit_zero || fin) : (hit_zero && !q.mode.circ);
        wrap        = !q.mode.pfc && q.mode.circ && hit_zero;

        if (flag_clr) begin
            d.tc  = 1'b0;
            d.err = 1'b0;
        end

        unique case (q.st)
            ST_IDLE: begin
                if (cfg_wr) begin
                    d.mode     = raw;
                    d.mode.pfc = eff.pfc;
                    if (cfg_en) begin
                        if (!eff.pfc && sw_zero) begin
                            d.err = 1'b1;
                        end else begin
                            d.st      = ST_RUN;
                            d.en      = 1'b1;
                            d.mode    = eff;
                            d.buf_sel = 1'b0;
                            ld        = 1'b1;
                            start     = 1'b1;
                            if (dropped) d.err = 1'b1;
                        end
                    end
                end
            end
            ST_RUN: begin
                if (natural_end) begin
                    d.st = ST_IDLE;
                    d.en = 1'b0;
                    d.tc = 1'b1;
                end else begin
                    if (wrap) begin
                        d.tc = 1'b1;
                        if (q.mode.dbuf) d.buf_sel = ~q.buf_sel;
                    end
                    if (abort) begin
                        d.en = 1'b0;
                        if (xfer_busy && !xfer_done) begin
                            d.st = ST_DRAIN;
                        end else begin
                            d.st    = ST_IDLE;
                            d.tc    = 1'b1;
                            d.flush = (q.mode.dir == DIR_P2M);
                        end
                    end
                end
            end
            ST_DRAIN: begin
                if (xfer_done || !xfer_busy) begin
                    d.st    = ST_IDLE;
                    d.en    = 1'b0;
                    d.tc    = 1'b1;
                    d.flush = (q.mode.dir == DIR_P2M);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, mode: '0, default: 1'b0};
        else        q <= d;
    end

    assign active     = (q.st != ST_IDLE);
    assign en_rd      = q.en;
    assign pfc_rd     = q.mode.pfc;
    assign circ_rd    = q.mode.circ;
    assign dbuf_rd    = q.mode.dbuf;
    assign burst_rd   = q.mode.burst;
    assign buf_sel    = q.buf_sel;
    assign flush      = q.flush;
    assign tc_flag    = q.tc;
    assign cfg_err    = q.err;
    assign run_m2m    = q.mode.dir[1];
    assign run_direct = q.mode.direct;
endmodule

// File: rtl/dma_term_chk.sv
module dma_term_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             active,
    input logic             en_rd,
    input logic             pfc_rd,
    input logic             circ_rd,
    input logic             dbuf_rd,
    input logic             burst_rd,
    input logic             flush,
    input logic             tc_flag,
    input logic [CNT_W-1:0] remaining,
    input logic             run_m2m,
    input logic             run_direct
);
    // R1
    pfc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) && pfc_rd |-> remaining == {CNT_W{1'b1}});

    // R2
    pfc_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active && $past(active) && pfc_rd |-> remaining <= $past(remaining));

    // R9
    m2m_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active && run_m2m |-> !pfc_rd && !circ_rd && !dbuf_rd);

    // R9
    pfc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active && pfc_rd |-> !circ_rd && !dbuf_rd);

    // R10
    direct_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active && run_direct |-> !burst_rd);

    // R7
    flush_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !active && tc_flag);

    // R13
    stop_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> !en_rd);

    // R11
    tc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tc_flag) |-> $past(active));
endmodule

bind dma_stream_term dma_term_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active),
    .en_rd      (en_rd),
    .pfc_rd     (pfc_rd),
    .circ_rd    (circ_rd),
    .dbuf_rd    (dbuf_rd),
    .burst_rd   (burst_rd),
    .flush      (flush),
    .tc_flag    (tc_flag),
    .remaining  (remaining),
    .run_m2m    (run_m2m),
    .run_direct (run_direct)
);

// File: tb/sim_dma_stream_term.sv
`timescale 1ns/1ps
module sim_dma_stream_term;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 0, cfg_en = 0, cfg_pfc = 0, cfg_circ = 0, cfg_direct = 0, cfg_dbuf = 0, cfg_burst = 0;
    logic [1:0] cfg_dir = 2'b00;
    logic cnt_wr = 0;
    logic [15:0] cnt_wdata = '0;
    logic flag_clr = 0, per_req = 0, per_last = 0, xfer_busy = 0, xfer_done = 0;
    logic [15:0] remaining;
    logic active, en_rd, pfc_rd, circ_rd, dbuf_rd, burst_rd, buf_sel, flush, tc_flag, cfg_err;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dma_stream_term u0 (.*);

    function automatic logic [15:0] exp_moved(input logic [15:0] rem);
        return 16'hFFFF - rem;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg(input logic en, input logic [1:0] dir, input logic pfc, input logic circ,
                       input logic direct, input logic dbuf, input logic burst);
        cfg_en = en; cfg_dir = dir; cfg_pfc = pfc; cfg_circ = circ;
        cfg_direct = direct; cfg_dbuf = dbuf; cfg_burst = burst;
        cfg_wr = 1'b1;
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic setcnt(input logic [15:0] v);
        cnt_wr = 1'b1; cnt_wdata = v;
        tick();
        cnt_wr = 1'b0;
    endtask

    task automatic done_n(input int n);
        for (int i = 0; i < n; i++) begin
            xfer_done = 1'b1;
            tick();
        end
        xfer_done = 1'b0;
    endtask

    task automatic lastreq();
        per_req = 1'b1; per_last = 1'b1;
        tick();
        per_req = 1'b0; per_last = 1'b0;
    endtask

    task automatic clr();
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state (R13, R11)
        chk("R13 reset active", active, 0);
        chk("R13 reset en", en_rd, 0);
        chk("R11 reset tc", tc_flag, 0);
        chk("R11 reset err", cfg_err, 0);
        chk("R2 reset remaining", remaining, 0);

        // peripheral flow, single final request
        setcnt(16'd7);
        cfg(1, 2'b00, 1, 0, 0, 0, 0);
        chk("R1 forced all-ones", remaining, 16'hFFFF);
        chk("R1 active", active, 1);
        done_n(3);
        chk("R2 three items", exp_moved(remaining), 3);
        lastreq();
        chk("R3 armed still active", active, 1);
        done_n(1);
        chk("R3 single end active", active, 0);
        chk("R3 single end tc", tc_flag, 1);
        chk("R2 moved after last", exp_moved(remaining), 4);
        chk("R3 no flush", flush, 0);
        chk("R13 en after end", en_rd, 0);
        clr();
        chk("R11 tc cleared", tc_flag, 0);

        // peripheral flow, burst final request
        cfg(1, 2'b01, 1, 0, 0, 0, 1);
        done_n(2);
        lastreq();
        done_n(3);
        chk("R3 burst beat3 active", active, 1);
        done_n(1);
        chk("R3 burst end active", active, 0);
        chk("R2 burst moved", exp_moved(remaining), 6);

        // abort P2M, nothing in flight
        clr();
        cfg(1, 2'b00, 1, 0, 0, 0, 0);
        done_n(2);
        cfg(0, 2'b00, 1, 0, 0, 0, 0);
        chk("R7 abort inactive", active, 0);
        chk("R7 abort flush", flush, 1);
        chk("R7 abort tc", tc_flag, 1);
        chk("R13 abort en", en_rd, 0);
        chk("R2 abort moved", exp_moved(remaining), 2);
        tick();
        chk("R7 flush one cycle", flush, 0);

        // set wins over clear
        cfg(1, 2'b00, 1, 0, 0, 0, 0);
        flag_clr = 1'b1;
        cfg(0, 2'b00, 1, 0, 0, 0, 0);
        flag_clr = 1'b0;
        chk("R11 set wins", tc_flag, 1);

        // abort with item in flight, M2P, DMA flow
        clr();
        setcnt(16'd10);
        cfg(1, 2'b01, 0, 0, 0, 0, 0);
        chk("R5 load sw count", remaining, 10);
        xfer_busy = 1'b1;
        cfg(0, 2'b01, 0, 0, 0, 0, 0);
        chk("R8 drain active", active, 1);
        chk("R8 drain en", en_rd, 0);
        tick();
        chk("R8 drain holds", active, 1);
        xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0; xfer_busy = 1'b0;
        chk("R8 drain ends", active, 0);
        chk("R8 item counted", remaining, 9);
        chk("R7 no flush M2P", flush, 0);
        chk("R8 tc", tc_flag, 1);

        // DMA flow run with ignored stimulus
        clr();
        setcnt(16'd5);
        cfg(1, 2'b01, 0, 0, 0, 0, 0);
        done_n(4);
        chk("R5 count 1 left", remaining, 1);
        lastreq();
        chk("R12 last ignored", active, 1);
        setcnt(16'd100);
        chk("R12 cnt write ignored", remaining, 1);
        cfg(1, 2'b01, 0, 1, 0, 0, 0);
        chk("R12 cfg write ignored", circ_rd, 0);
        done_n(1);
        chk("R5 end active", active, 0);
        chk("R5 end tc", tc_flag, 1);
        chk("R5 end remaining", remaining, 0);

        // circular with double buffer
        clr();
        setcnt(16'd3);
        cfg(1, 2'b01, 0, 1, 0, 1, 0);
        chk("R6 buf start", buf_sel, 0);
        done_n(3);
        chk("R6 wrap tc", tc_flag, 1);
        chk("R6 wrap active", active, 1);
        chk("R6 reload", remaining, 3);
        chk("R6 buf toggle", buf_sel, 1);
        chk("R6 no err", cfg_err, 0);
        cfg(0, 2'b01, 0, 1, 0, 1, 0);

        // memory-to-memory masking
        clr();
        setcnt(16'd4);
        cfg(1, 2'b10, 1, 1, 0, 1, 0);
        chk("R9 m2m pfc", pfc_rd, 0);
        chk("R9 m2m circ", circ_rd, 0);
        chk("R9 m2m dbuf", dbuf_rd, 0);
        chk("R9 m2m err", cfg_err, 1);
        chk("R9 m2m count", remaining, 4);
        cfg(0, 2'b10, 0, 0, 0, 0, 0);

        // peripheral flow masks circular
        clr();
        cfg(1, 2'b00, 1, 1, 0, 0, 0);
        chk("R9 pfc circ", circ_rd, 0);
        chk("R9 pfc err", cfg_err, 1);
        cfg(0, 2'b00, 1, 0, 0, 0, 0);

        // direct mode burst downgrade
        clr();
        setcnt(16'd2);
        cfg(1, 2'b01, 0, 0, 1, 0, 1);
        chk("R10 burst single", burst_rd, 0);
        chk("R10 err", cfg_err, 1);
        cfg(0, 2'b01, 0, 0, 0, 0, 0);

        // zero count refused
        clr();
        setcnt(16'd0);
        cfg(1, 2'b01, 0, 0, 0, 0, 0);
        chk("R5 zero refused active", active, 0);
        chk("R5 zero refused en", en_rd, 0);
        chk("R5 zero refused err", cfg_err, 1);

        // random peripheral-flow sessions
        for (int it = 0; it < 24; it++) begin
            int k;
            logic b;
            logic [1:0] dr;
            k  = int'($urandom % 20);
            b  = 1'($urandom % 2);
            dr = 2'($urandom % 2);
            clr();
            cfg(1, dr, 1, 0, 0, 0, b);
            done_n(k);
            lastreq();
            done_n(b ? 4 : 1);
            chk("R3 random end", active, 0);
            chk("R2 random moved", exp_moved(remaining), k + (b ? 4 : 1));
        end

        // random DMA-flow sessions
        for (int it = 0; it < 12; it++) begin
            int n;
            n = 1 + int'($urandom % 30);
            clr();
            setcnt(16'(n));
            cfg(1, 2'($urandom % 2), 0, 0, 0, 0, 0);
            done_n(n - 1);
            chk("R5 random still active", active, 1);
            done_n(1);
            chk("R5 random end", active, 0);
            chk("R5 random tc", tc_flag, 1);
        end

        // peripheral flow count exhaustion
        clr();
        cfg(1, 2'b00, 1, 0, 0, 0, 0);
        xfer_done = 1'b1;
        repeat (65534) tick();
        chk("R4 one left", remaining, 1);
        chk("R4 still active", active, 1);
        tick();
        xfer_done = 1'b0;
        chk("R4 forced end", active, 0);
        chk("R4 tc", tc_flag, 1);
        chk("R4 moved max", exp_moved(remaining), 16'hFFFF);
        chk("R4 no flush", flush, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule